// File: doc/BRIEF.md
# Dual Audio Rate Tick Generator

This block produces two audio-rate tick streams in the system clock domain. One generator is aimed at the 44.1 kHz sample-rate family and the other at the 48 kHz family. Each generator picks one of four audio reference inputs, and each input arrives as a single-cycle enable strobe. The generator counts strobes from the chosen input through a power-of-four prescaler and then an 8-bit fine divider. When a full divide period is complete it emits a single-cycle tick.

A small register write port programs the block. A control word selects the reference input for each generator and chooses which generator drives the shared clock-output tick. A separate divide word for each generator holds a 2-bit prescale code and an 8-bit count N. Because every input is a strobe, there is no clock multiplexing: changing a source only changes which strobe is counted.

Top module: `audio_rate_gen`

## Requirements
- R1: After reset, all three tick outputs are low and the control word is zero, so both generators count input 0 and the clock output follows generator A. Both divide words reset to 0x0FF, so each generator ticks once every 512 strobes of its input.
- R2: A generator ticks once for every P*(N+1) counted strobes. The tick is high for exactly one cycle, the cycle after the edge at which the completing strobe is sampled.
- R3: In a divide word, bits [9:8] hold the prescale code k and bits [7:0] hold N. The prescale ratio P is 2, 8, 32 or 128 for k = 0, 1, 2, 3.
- R4: The source of generator A is control bits [22:20] and the source of generator B is control bits [18:16]. Code 0 selects input 0, code 1 selects input 1, code 4 selects input 2 and code 2 selects input 3.
- R5: A source code other than 0, 1, 2 or 4 selects no input, and that generator's tick stays low whatever the strobes do.
- R6: When control bit 31 is 1, the clock output tick repeats generator B's tick. When it is 0, it repeats generator A's tick.
- R7: A control write stores only bits 31, 22:20 and 18:16 (mask 0x80770000). All other bits of the written data have no effect on behaviour.
- R8: A write to a divide word restarts that generator's prescale and fine counts from zero, and that generator does not tick in the cycle after the write.
- R9: A tick output is never high on two consecutive cycles.
- R10: A generator ticks only in the cycle after a strobe on its selected input. Strobes on the other inputs do not advance it.
- R11: The write target code is wr_sel: 0 for control, 1 for divide A, 2 for divide B. A write with wr_sel = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 divide A, 2 divide B, 3 none |
| wr_data | input | 32 | Write data |
| src_en | input | 4 | Per-input reference strobes, bit i is input i |
| tick_a | output | 1 | Generator A tick |
| tick_b | output | 1 | Generator B tick |
| tick_out | output | 1 | Clock-output tick, from A or B per control bit 31 |

## Verification
The assertions assume that the strobes and write inputs are synchronous and settle before each rising edge. They also assume that no strobes arrive in the same cycle as a write, because the tick-after-strobe property compares a tick against the previous cycle's source selection. The bench drives every input just after the falling edge. Its write task holds all strobes low during the write cycle, and the random phase reconfigures only through that task. Random strobe density and small random divide words keep many periods in the run. Directed cases cover every prescale code, every source code, the reset period, mid-period restarts and the masked control bits.

// File: rtl/arg_pkg.sv
package arg_pkg;
    localparam int NUM_IN      = 4;
    localparam int CTRL_W      = 32;
    localparam int SRC_W       = 3;
    localparam int SRC_A_LSB   = 20;
    localparam int SRC_B_LSB   = 16;
    localparam int OUT_SEL_BIT = 31;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h8077_0000;

    typedef enum logic [1:0] {
        WR_CTRL  = 2'd0,
        WR_DIV_A = 2'd1,
        WR_DIV_B = 2'd2,
        WR_NONE  = 2'd3
    } wr_tgt_e;

    // Non-linear source code map: 0->in0, 1->in1, 4->in2, 2->in3
    function automatic logic src_hit(input logic [SRC_W-1:0] code,
                                     input logic [NUM_IN-1:0] en);
        case (code)
            3'd0:    return en[0];
            3'd1:    return en[1];
            3'd4:    return en[2];
            3'd2:    return en[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic src_valid(input logic [SRC_W-1:0] code);
        return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) || (code == 3'd4);
    endfunction
endpackage

// File: rtl/arg_src_sel.sv
module arg_src_sel
    import arg_pkg::*;
(
    input  logic [SRC_W-1:0]  code,
    input  logic [NUM_IN-1:0] src_en,
    output logic              strobe
);
    always_comb begin
        strobe = src_hit(code, src_en);
    end
endmodule

// File: rtl/arg_divider.sv
module arg_divider #(
    parameter int PRE_W  = 2,
    parameter int FINE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PRE_W+FINE_W-1:0] load_val,
    input  logic                    strobe,
    output logic                    tick
);
    localparam int DIV_W  = PRE_W + FINE_W;
    localparam int PCNT_W = 2 * ((1 << PRE_W) - 1) + 1;
    localparam logic [DIV_W-1:0] RST_DIV = DIV_W'((1 << FINE_W) - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [PCNT_W-1:0] pcnt;
        logic [FINE_W-1:0] fcnt;
        logic              tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [31:0]       shamt;
    logic [PCNT_W-1:0] pre_lim;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        shamt     = 32'(st_q.div[DIV_W-1:FINE_W]) * 32'd2 + 32'd1;
        pre_lim   = PCNT_W'((32'd1 << shamt) - 32'd1);
        if (load) begin
            st_d.div  = load_val;
            st_d.pcnt = '0;
            st_d.fcnt = '0;
        end else if (strobe) begin
            if (st_q.pcnt == pre_lim) begin
                st_d.pcnt = '0;
                if (st_q.fcnt == st_q.div[FINE_W-1:0]) begin
                    st_d.fcnt = '0;
                    st_d.tick = 1'b1;
                end else begin
                    st_d.fcnt = st_q.fcnt + 1'b1;
                end
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div  <= RST_DIV;
            st_q.pcnt <= '0;
            st_q.fcnt <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/audio_rate_gen.sv
module audio_rate_gen
    import arg_pkg::*;
#(
    parameter int PRE_W  = 2,
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [NUM_IN-1:0] src_en,
    output logic              tick_a,
    output logic              tick_b,
    output logic              tick_out
);
    localparam int NUM_GEN = 2;
    localparam int DIV_W   = PRE_W + FINE_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [NUM_GEN-1:0] ticks;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_tgt_e'(wr_sel) == WR_CTRL)) begin
            st_d.ctrl = wr_data & CTRL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam int      LSB = (g == 0) ? SRC_A_LSB : SRC_B_LSB;
        localparam wr_tgt_e TGT = (g == 0) ? WR_DIV_A : WR_DIV_B;
        logic strobe;
        logic load;

        assign load = wr_en && (wr_tgt_e'(wr_sel) == TGT);

        arg_src_sel u_sel (
            .code   (ctrl_q[LSB +: SRC_W]),
            .src_en (src_en),
            .strobe (strobe)
        );

        arg_divider #(
            .PRE_W  (PRE_W),
            .FINE_W (FINE_W)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (wr_data[DIV_W-1:0]),
            .strobe   (strobe),
            .tick     (ticks[g])
        );
    end

    assign tick_a   = ticks[0];
    assign tick_b   = ticks[1];
    assign tick_out = ctrl_q[OUT_SEL_BIT] ? ticks[1] : ticks[0];
endmodule

// File: rtl/audio_rate_gen_chk.sv
module audio_rate_gen_chk
    import arg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [NUM_IN-1:0] src_en,
    input logic [CTRL_W-1:0] ctrl,
    input logic              tick_a,
    input logic              tick_b,
    input logic              tick_out
);
    // R9
    tick_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |=> !tick_a);

    // R9
    tick_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b |=> !tick_b);

    // R10
    tick_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |-> $past(src_hit(ctrl[SRC_A_LSB +: SRC_W], src_en)));

    // R10
    tick_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b |-> $past(src_hit(ctrl[SRC_B_LSB +: SRC_W], src_en)));

    // R5
    bad_code_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |-> $past(src_valid(ctrl[SRC_A_LSB +: SRC_W])));

    // R8
    restart_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_DIV_A) |=> !tick_a);

    // R8
    restart_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_DIV_B) |=> !tick_b);

    // R6
    out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> (tick_a || tick_b));

    // R11
    null_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_NONE) |=> $stable(ctrl));
endmodule

bind audio_rate_gen audio_rate_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .src_en   (src_en),
    .ctrl     (ctrl_q),
    .tick_a   (tick_a),
    .tick_b   (tick_b),
    .tick_out (tick_out)
);

// File: tb/audio_rate_gen_bench.sv
module audio_rate_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [3:0]  src_en = '0;
    logic        tick_a, tick_b, tick_out;

    int total = 0;
    int bad = 0;
    string cur = "R1";

    logic [31:0] m_ctrl;
    logic [9:0]  m_div [2];
    int          m_cnt [2];
    logic        m_tick [2];
    int          seen_a, seen_b;

    always #4 clk = ~clk;

    audio_rate_gen u_audio_rate_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .src_en(src_en),
        .tick_a(tick_a), .tick_b(tick_b), .tick_out(tick_out)
    );

    function automatic int period(input logic [9:0] d);
        return (2 << (2 * int'(d[9:8]))) * (int'(d[7:0]) + 1);
    endfunction

    function automatic logic sel_hit(input logic [2:0] c, input logic [3:0] e);
        if (c == 3'd0) return e[0];
        if (c == 3'd1) return e[1];
        if (c == 3'd4) return e[2];
        if (c == 3'd2) return e[3];
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outs();
        chk(cur, "tick_a", int'(tick_a), int'(m_tick[0]));
        chk(cur, "tick_b", int'(tick_b), int'(m_tick[1]));
        chk(cur, "tick_out", int'(tick_out), int'(m_ctrl[31] ? m_tick[1] : m_tick[0]));
        if (tick_a) seen_a++;
        if (tick_b) seen_b++;
    endtask

    task automatic step(input logic [3:0] en);
        src_en = en;
        @(posedge clk);
        for (int g = 0; g < 2; g++) begin
            logic [2:0] c;
            c = (g == 0) ? m_ctrl[22:20] : m_ctrl[18:16];
            m_tick[g] = 1'b0;
            if (sel_hit(c, en)) begin
                m_cnt[g]++;
                if (m_cnt[g] == period(m_div[g])) begin
                    m_cnt[g] = 0;
                    m_tick[g] = 1'b1;
                end
            end
        end
        @(negedge clk);
        check_outs();
    endtask

    task automatic wr(input logic [1:0] tgt, input logic [31:0] data);
        src_en = '0;
        wr_en = 1'b1;
        wr_sel = tgt;
        wr_data = data;
        @(posedge clk);
        if (tgt == 2'd0) m_ctrl = data & 32'h8077_0000;
        if (tgt == 2'd1) begin m_div[0] = data[9:0]; m_cnt[0] = 0; end
        if (tgt == 2'd2) begin m_div[1] = data[9:0]; m_cnt[1] = 0; end
        m_tick[0] = 1'b0;
        m_tick[1] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check_outs();
    endtask

    function automatic logic [31:0] ctrl_word(input logic sel_b, input logic [2:0] ca,
                                              input logic [2:0] cb);
        return {sel_b, 8'd0, ca, 1'b0, cb, 16'd0};
    endfunction

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed);
        m_ctrl = '0;
        m_div[0] = 10'h0FF; m_div[1] = 10'h0FF;
        m_cnt[0] = 0; m_cnt[1] = 0;
        m_tick[0] = 1'b0; m_tick[1] = 1'b0;
        seen_a = 0; seen_b = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_outs();
        rst_n = 1'b1;
        cur = "R1";
        for (int i = 0; i < 520; i++) step(4'b0001);
        chk("R1", "ticks in 520 strobes", seen_a, 1);

        // R3 / R2: each prescale code with N=2
        for (int k = 0; k < 4; k++) begin
            cur = "R3";
            wr(2'd1, {22'd0, 2'(k), 8'd2});
            seen_a = 0;
            for (int i = 0; i < 2 * period({2'(k), 8'd2}) + 3; i++) step(4'b0001);
            chk("R2", "two periods of ticks", seen_a, 2);
        end

        // R4 / R10: source code map, one input strobing at a time
        cur = "R4";
        wr(2'd1, 32'h0000_0001);
        wr(2'd2, 32'h0000_0000);
        for (int c = 0; c < 8; c++) begin
            if (c == 3 || c > 4) continue;
            wr(2'd0, ctrl_word(1'b0, 3'(c), 3'(c)));
            for (int i = 0; i < 4; i++) begin
                cur = "R10";
                for (int n = 0; n < 9; n++) step(4'(1 << i));
            end
        end

        // R5: unlisted codes never tick
        for (int c = 3; c < 8; c++) begin
            if (c == 4) continue;
            cur = "R5";
            wr(2'd0, ctrl_word(1'b1, 3'(c), 3'(c)));
            seen_a = 0; seen_b = 0;
            for (int n = 0; n < 20; n++) step(4'b1111);
            chk("R5", "ticks with unlisted code", seen_a + seen_b, 0);
        end

        // R6 / R9: output routing, fastest divide
        cur = "R6";
        wr(2'd1, 32'h0000_0000);
        wr(2'd2, 32'h0000_0102);
        wr(2'd0, ctrl_word(1'b1, 3'd0, 3'd1));
        for (int n = 0; n < 40; n++) step(4'b0011);
        cur = "R9";
        wr(2'd0, ctrl_word(1'b0, 3'd0, 3'd1));
        for (int n = 0; n < 40; n++) step(4'b0011);

        // R7: bits outside the mask are dropped
        cur = "R7";
        wr(2'd0, 32'h7F88_FFFF);
        for (int n = 0; n < 12; n++) step(4'b0001);
        seen_a = 0;
        wr(2'd0, 32'hFFFF_FFFF);
        for (int n = 0; n < 12; n++) step(4'b1111);
        chk("R7", "all-ones control gives no A ticks", seen_a, 0);

        // R11: null target writes nothing
        cur = "R11";
        wr(2'd0, ctrl_word(1'b0, 3'd1, 3'd1));
        wr(2'd3, 32'hFFFF_FFFF);
        for (int n = 0; n < 12; n++) step(4'b0010);

        // R8: restart mid-period
        cur = "R8";
        wr(2'd1, 32'h0000_0007);
        for (int n = 0; n < 10; n++) step(4'b0010);
        wr(2'd1, 32'h0000_0007);
        seen_a = 0;
        for (int n = 0; n < 15; n++) step(4'b0010);
        chk("R8", "no tick before full period after restart", seen_a, 0);
        step(4'b0010);
        chk("R8", "tick at full period after restart", seen_a, 1);

        // Random phase
        cur = "R2";
        for (int blk = 0; blk < 15; blk++) begin
            logic [2:0] codes [6];
            codes = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd3, 3'd6};
            wr(2'd1, {22'd0, 2'($urandom_range(0, 1)), 8'($urandom_range(0, 7))});
            wr(2'd2, {22'd0, 2'($urandom_range(0, 1)), 8'($urandom_range(0, 7))});
            wr(2'd0, ctrl_word(1'($urandom_range(0, 1)),
                               codes[$urandom_range(0, 5)], codes[$urandom_range(0, 5)]));
            for (int n = 0; n < 200; n++) step(4'($urandom_range(0, 15)));
        end

        summary();
    end
endmodule